// File: doc/BRIEF.md
# Selectable-Clock Free-Running Timer Channel

This block is one channel of a multi-channel timer unit: a 16-bit up-counter whose count enable comes from one of several sources. The sources are a prescaled internal strobe, two external clock pins, an event strobe from a neighbouring channel, or a multiplied version of that event strobe. A start bit, driven from the shared start register outside the channel, gates the counting. Software reaches the counter, a compare value, a control word and an overflow status bit through a word-wide register port.

The counter can be returned to zero in two ways. A clear trigger from a controlling channel acts when it coincides with a count step. A match against the compare register acts on the step after the match. When the count carries out of 0xFFFF, a sticky overflow flag is set. Software clears that flag by reading it as 1 and then writing 0 to it. Power-on reset and either standby input return the counter and the flag to zero.

Top module: `frt_channel`

## Requirements
- R1: After reset, the counter reads 0x0000, the status reads 0, the control word reads 0 and the compare register reads 0xFFFF. Either standby input forces the counter and the overflow flag to 0 at the next clock edge.
- R2: The counter advances by exactly one per system-clock cycle in which `run` is 1 and the selected strobe is 1. While `run` is 0 it holds its value.
- R3: The control word (address 2) has three fields: bits [2:0] select the source, bits [4:3] select the prescaler strobe, and bits [6:5] select the clear mode. With source code 0, the counter steps on `presc_tick[psel]` and ignores the other prescaler bits.
- R4: Source codes 1 and 2 count the rising edges of `ext_pin_a` and `ext_pin_b`. Each pin passes through a two-stage synchroniser, and the other pin has no effect.
- R5: Source code 3 steps on `evt_tick` and source code 4 steps on `evt_mul_tick`. Codes 5 to 7 never step.
- R6: A step taken at 0xFFFF that is not a clear takes the counter to 0x0000 and sets status bit 0.
- R7: A full-word write of 0 to the status register (address 3) clears the flag only after the flag has been read as 1. Writing 1 leaves the flag unchanged.
- R8: An overflow in the same cycle as a clearing status write leaves the flag set.
- R9: In clear mode 1, a step that coincides with `clr_trig` loads 0. `clr_trig` without a step, or in any other clear mode, has no effect.
- R10: In clear mode 2, a step taken while the counter equals the compare register (address 1) loads 0, so the count cycles through 0 to compare value.
- R11: A full-word write to the counter (address 0) loads the written data. It takes priority over a step, a trigger clear or a match clear in the same cycle.
- R12: Only accesses with both byte enables set take effect. Other writes change nothing, and other reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| stby_hw | input | 1 | Hardware standby, clears counter and flag |
| stby_sw | input | 1 | Software standby, clears counter and flag |
| run | input | 1 | This channel's start bit |
| presc_tick | input | 4 | Prescaled internal strobes, one cycle wide |
| ext_pin_a | input | 1 | External clock pin A (asynchronous) |
| ext_pin_b | input | 1 | External clock pin B (asynchronous) |
| evt_tick | input | 1 | Event strobe from the neighbouring channel |
| evt_mul_tick | input | 1 | Multiplied event strobe from the neighbouring channel |
| clr_trig | input | 1 | Clear trigger from the controlling channel |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | 0 counter, 1 compare, 2 control, 3 status |
| bus_be | input | 2 | Byte enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational during a read |

## Verification
The properties take for granted that every strobe input (`presc_tick`, `evt_tick`, `evt_mul_tick`, `clr_trig`) is already a single-cycle pulse in the system-clock domain, and that only the pins are asynchronous. They also assume that standby and a register write may coincide with a step, but that standby always wins. The bench drives every input at the falling edge, so each strobe is high for exactly one rising edge. It holds each pin level for at least two cycles so that no synchroniser edge is lost. It also lets the pins settle for several cycles before it reads the count.

// File: rtl/frt_pkg.sv
package frt_pkg;

    localparam int PSEL_W = 2;
    localparam int NPRE   = 1 << PSEL_W;
    localparam int ADDR_W = 2;

    typedef enum logic [2:0] {
        SRC_PRESC   = 3'd0,
        SRC_PIN_A   = 3'd1,
        SRC_PIN_B   = 3'd2,
        SRC_EVT     = 3'd3,
        SRC_EVT_MUL = 3'd4,
        SRC_RSV5    = 3'd5,
        SRC_RSV6    = 3'd6,
        SRC_RSV7    = 3'd7
    } src_e;

    typedef enum logic [1:0] {
        CLR_NONE  = 2'd0,
        CLR_TRIG  = 2'd1,
        CLR_MATCH = 2'd2,
        CLR_RSV   = 2'd3
    } clr_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CNT  = 2'd0,
        RA_CMP  = 2'd1,
        RA_CTRL = 2'd2,
        RA_STAT = 2'd3
    } reg_e;

    // packed MSB first: clr [6:5], psel [4:3], src [2:0]
    typedef struct packed {
        clr_e              clr;
        logic [PSEL_W-1:0] psel;
        src_e              src;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic clr_active(input clr_e mode, input logic trig, input logic match);
        return ((mode == CLR_TRIG) && trig) || ((mode == CLR_MATCH) && match);
    endfunction

endpackage

// File: rtl/frt_src_sel.sv
module frt_src_sel
    import frt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NPINS       = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [NPRE-1:0]  presc_tick,
    input  logic [NPINS-1:0] pin,
    input  logic             evt_tick,
    input  logic             evt_mul_tick,
    output logic             tick
);

    logic [NPINS-1:0] pin_edge;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [SYNC_STAGES:0] shreg;
        always_ff @(posedge clk) begin
            if (rst) shreg <= '0;
            else     shreg <= {shreg[SYNC_STAGES-1:0], pin[p]};
        end
        assign pin_edge[p] = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
    end

    always_comb begin
        case (ctrl.src)
            SRC_PRESC:   tick = presc_tick[ctrl.psel];
            SRC_PIN_A:   tick = pin_edge[0];
            SRC_PIN_B:   tick = pin_edge[NPINS-1];
            SRC_EVT:     tick = evt_tick;
            SRC_EVT_MUL: tick = evt_mul_tick;
            default:     tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/frt_counter.sv
module frt_counter
    import frt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stby,
    input  logic         run,
    input  logic         tick,
    input  clr_e         clr_mode,
    input  logic         clr_trig,
    input  logic [W-1:0] cmp,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt,
    output logic         step,
    output logic         clr_hit,
    output logic         ovf_set
);

    logic match;
    logic carry;

    assign step    = run & tick;
    assign match   = (cnt == cmp);
    assign carry   = &cnt;
    assign clr_hit = step & clr_active(clr_mode, clr_trig, match);
    assign ovf_set = step & ~clr_hit & carry & ~wr_en & ~stby;

    always_ff @(posedge clk) begin
        if (rst || stby)  cnt <= '0;
        else if (wr_en)   cnt <= wr_data;
        else if (clr_hit) cnt <= '0;
        else if (step)    cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/frt_regif.sv
module frt_regif
    import frt_pkg::*;
#(
    parameter int W = 16,
    localparam int BE_W = W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stby,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      cnt,
    input  logic              ovf_set,
    output logic              cnt_wr,
    output ctrl_t             ctrl,
    output logic [W-1:0]      cmp,
    output logic              ovf,
    output logic [W-1:0]      rdata
);

    logic word, wr_ok, rd_ok, stat_wr, stat_rd, clr_req, armed;
    reg_e ra;

    assign ra      = reg_e'(bus_addr);
    assign word    = &bus_be;
    assign wr_ok   = bus_sel & bus_wr & word;
    assign rd_ok   = bus_sel & ~bus_wr & word;
    assign cnt_wr  = wr_ok && (ra == RA_CNT);
    assign stat_wr = wr_ok && (ra == RA_STAT);
    assign stat_rd = rd_ok && (ra == RA_STAT);
    assign clr_req = stat_wr & armed & ~bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp  <= '1;
            ctrl <= '0;
        end else if (wr_ok) begin
            if (ra == RA_CMP)  cmp  <= bus_wdata;
            if (ra == RA_CTRL) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || stby) begin
            ovf   <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (ovf_set)      ovf <= 1'b1;
            else if (clr_req) ovf <= 1'b0;
            if (clr_req)             armed <= 1'b0;
            else if (stat_rd && ovf) armed <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_ok) begin
            case (ra)
                RA_CNT:  rdata = cnt;
                RA_CMP:  rdata = cmp;
                RA_CTRL: rdata[CTRL_W-1:0] = ctrl;
                RA_STAT: rdata[0] = ovf;
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/frt_channel.sv
module frt_channel
    import frt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int BE_W       = CNT_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stby_hw,
    input  logic              stby_sw,
    input  logic              run,
    input  logic [NPRE-1:0]   presc_tick,
    input  logic              ext_pin_a,
    input  logic              ext_pin_b,
    input  logic              evt_tick,
    input  logic              evt_mul_tick,
    input  logic              clr_trig,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata
);

    logic             stby;
    logic             tick, step, clr_hit, ovf_set, cnt_wr, ovf_q;
    logic [CNT_W-1:0] cnt_q, cmp_q;
    ctrl_t            ctrl_q;

    assign stby = stby_hw | stby_sw;

    frt_src_sel #(.SYNC_STAGES(SYNC_STAGES), .NPINS(2)) u_src (
        .clk          (clk),
        .rst          (rst),
        .ctrl         (ctrl_q),
        .presc_tick   (presc_tick),
        .pin          ({ext_pin_b, ext_pin_a}),
        .evt_tick     (evt_tick),
        .evt_mul_tick (evt_mul_tick),
        .tick         (tick)
    );

    frt_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .stby     (stby),
        .run      (run),
        .tick     (tick),
        .clr_mode (ctrl_q.clr),
        .clr_trig (clr_trig),
        .cmp      (cmp_q),
        .wr_en    (cnt_wr),
        .wr_data  (bus_wdata),
        .cnt      (cnt_q),
        .step     (step),
        .clr_hit  (clr_hit),
        .ovf_set  (ovf_set)
    );

    frt_regif #(.W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .stby      (stby),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .cnt       (cnt_q),
        .ovf_set   (ovf_set),
        .cnt_wr    (cnt_wr),
        .ctrl      (ctrl_q),
        .cmp       (cmp_q),
        .ovf       (ovf_q),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/frt_channel_chk.sv
module frt_channel_chk
    import frt_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         stby,
    input logic [W-1:0] cnt,
    input logic         step,
    input logic         clr_hit,
    input logic         cnt_wr,
    input logic [W-1:0] wdata,
    input logic         ovf,
    input logic         ovf_set,
    input clr_e         clr_mode,
    input logic [W-1:0] cmp
);

    // R1
    stby_clear_chk: assert property (@(posedge clk) disable iff (rst)
        stby |=> (cnt == '0) && !ovf);

    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !cnt_wr && !stby) |=> $stable(cnt));

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !clr_hit && !cnt_wr && !stby) |=> cnt == W'($past(cnt) + 1'b1));

    // R6
    wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (step && (&cnt) && !clr_hit && !cnt_wr && !stby) |=> ovf && (cnt == '0));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_set |=> ovf);

    // R10
    match_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (step && clr_mode == CLR_MATCH && cnt == cmp && !cnt_wr && !stby) |=> cnt == '0);

    // R11
    wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && !stby) |=> cnt == $past(wdata));

endmodule

bind frt_channel frt_channel_chk #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .stby     (stby),
    .cnt      (cnt_q),
    .step     (step),
    .clr_hit  (clr_hit),
    .cnt_wr   (cnt_wr),
    .wdata    (bus_wdata),
    .ovf      (ovf_q),
    .ovf_set  (ovf_set),
    .clr_mode (ctrl_q.clr),
    .cmp      (cmp_q)
);

// File: tb/frt_channel_bench.sv
module frt_channel_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stby_hw = 1'b0, stby_sw = 1'b0, run = 1'b0;
    logic [3:0]  presc_tick = '0;
    logic        ext_pin_a = 1'b0, ext_pin_b = 1'b0;
    logic        evt_tick = 1'b0, evt_mul_tick = 1'b0, clr_trig = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [1:0]  bus_be = 2'b11;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    frt_channel u_frt_channel (
        .clk(clk), .rst(rst), .stby_hw(stby_hw), .stby_sw(stby_sw), .run(run),
        .presc_tick(presc_tick), .ext_pin_a(ext_pin_a), .ext_pin_b(ext_pin_b),
        .evt_tick(evt_tick), .evt_mul_tick(evt_mul_tick), .clr_trig(clr_trig),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    localparam logic [1:0] A_CNT = 2'd0, A_CMP = 2'd1, A_CTRL = 2'd2, A_STAT = 2'd3;

    function automatic logic [15:0] ctl(input int src, input int psel, input int clr);
        return 16'((clr << 5) | (psel << 3) | src);
    endfunction

    task automatic cyc();
        @(negedge clk);
        presc_tick = '0; evt_tick = 0; evt_mul_tick = 0; clr_trig = 0;
        bus_sel = 0; bus_wr = 0; bus_be = 2'b11; stby_hw = 0; stby_sw = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = 2'b11;
        cyc();
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = 2'b11;
        #1 d = bus_rdata;
        cyc();
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
        logic [15:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] e, d;
        int n, n2;
        repeat (3) @(negedge clk);
        rst = 0;
        cyc();

        // R1 reset state
        rd_chk(A_CNT, 16'h0000, "R1 cnt reset");
        rd_chk(A_STAT, 16'h0000, "R1 stat reset");
        rd_chk(A_CTRL, 16'h0000, "R1 ctrl reset");
        rd_chk(A_CMP, 16'hFFFF, "R1 cmp reset");

        // R2 stopped counter holds
        wr(A_CNT, 16'h0010);
        repeat (5) begin presc_tick = 4'hF; cyc(); end
        rd_chk(A_CNT, 16'h0010, "R2 run=0 hold");
        run = 1;

        // R3 prescaler selection sweep
        for (int p = 0; p < 4; p++) begin
            wr(A_CTRL, ctl(0, p, 0));
            wr(A_CNT, 16'h0000);
            n = 0;
            for (int c = 0; c < 30; c++) begin
                for (int i = 0; i < 4; i++) presc_tick[i] = (c % (i + 2)) == 0;
                if ((c % (p + 2)) == 0) n++;
                cyc();
            end
            rd_chk(A_CNT, 16'(n), $sformatf("R3 psel=%0d", p));
        end

        // R4 external pins, other pin ignored
        for (int s = 0; s < 2; s++) begin
            logic pa, pb;
            wr(A_CTRL, ctl(1 + s, 0, 0));
            wr(A_CNT, 16'h0000);
            n = 0; pa = 0; pb = 0;
            for (int c = 0; c < 24; c++) begin
                ext_pin_a = (c % 4) < 2;
                ext_pin_b = (c % 6) < 3;
                if (s == 0 && ext_pin_a && !pa) n++;
                if (s == 1 && ext_pin_b && !pb) n++;
                pa = ext_pin_a; pb = ext_pin_b;
                cyc();
            end
            ext_pin_a = 0; ext_pin_b = 0;
            repeat (4) cyc();
            rd_chk(A_CNT, 16'(n), $sformatf("R4 pin %s", s == 0 ? "A" : "B"));
        end

        // R5 event and multiplied event, reserved code
        for (int s = 3; s < 6; s++) begin
            wr(A_CTRL, ctl(s, 0, 0));
            wr(A_CNT, 16'h0000);
            n = 0; n2 = 0;
            for (int c = 0; c < 20; c++) begin
                evt_tick = (c % 3) == 0;
                evt_mul_tick = (c % 5) == 0;
                presc_tick = 4'hF;
                if (evt_tick) n++;
                if (evt_mul_tick) n2++;
                cyc();
            end
            rd_chk(A_CNT, s == 3 ? 16'(n) : (s == 4 ? 16'(n2) : 16'h0),
                   $sformatf("R5 src=%0d", s));
        end

        // R6 wraparound
        wr(A_CTRL, ctl(0, 0, 0));
        wr(A_CNT, 16'hFFFE);
        presc_tick = 4'h1; cyc();
        rd_chk(A_CNT, 16'hFFFF, "R6 before wrap cnt");
        rd_chk(A_STAT, 16'h0000, "R6 before wrap flag");
        presc_tick = 4'h1; cyc();
        rd_chk(A_CNT, 16'h0000, "R6 wrap cnt");
        rd_chk(A_STAT, 16'h0001, "R6 wrap flag");

        // R7 clear protocol (flag was read as 1 above)
        wr(A_STAT, 16'h0001);
        rd_chk(A_STAT, 16'h0001, "R7 write 1 keeps flag");
        wr(A_STAT, 16'h0000);
        rd_chk(A_STAT, 16'h0000, "R7 read then write 0 clears");
        wr(A_CNT, 16'hFFFF);
        presc_tick = 4'h1; cyc();
        wr(A_STAT, 16'h0000);
        rd_chk(A_STAT, 16'h0001, "R7 write 0 without read ignored");
        wr(A_STAT, 16'h0000);
        rd_chk(A_STAT, 16'h0000, "R7 cleared after read");

        // R8 new overflow beats clearing write
        wr(A_CNT, 16'hFFFF);
        presc_tick = 4'h1; cyc();
        rd_chk(A_STAT, 16'h0001, "R8 flag set");
        wr(A_CNT, 16'hFFFF);
        presc_tick = 4'h1; bus_sel = 1; bus_wr = 1; bus_addr = A_STAT; bus_wdata = 16'h0000;
        cyc();
        rd_chk(A_STAT, 16'h0001, "R8 set wins");
        rd_chk(A_CNT, 16'h0000, "R8 count wrapped");

        // R9 trigger clear
        wr(A_CTRL, ctl(0, 0, 1));
        wr(A_CNT, 16'h0005);
        presc_tick = 4'h1; clr_trig = 1; cyc();
        rd_chk(A_CNT, 16'h0000, "R9 trig with step");
        wr(A_CNT, 16'h0005);
        clr_trig = 1; cyc();
        rd_chk(A_CNT, 16'h0005, "R9 trig without step");
        wr(A_CTRL, ctl(0, 0, 0));
        presc_tick = 4'h1; clr_trig = 1; cyc();
        rd_chk(A_CNT, 16'h0006, "R9 trig in mode 0");

        // R10 compare clear sweep
        wr(A_CTRL, ctl(0, 0, 2));
        for (int m = 0; m < 5; m++) begin
            wr(A_CMP, 16'(m));
            wr(A_CNT, 16'h0000);
            e = 0;
            for (int k = 0; k < 8; k++) begin
                presc_tick = 4'h1; cyc();
                e = (e == 16'(m)) ? 16'h0 : e + 1'b1;
                rd_chk(A_CNT, e, $sformatf("R10 cmp=%0d step=%0d", m, k));
            end
        end
        rd(A_CNT, d);
        rd_chk(A_CNT, d, "R10 hold at match without step");

        // R11 write priority
        wr(A_CMP, 16'h0001);
        wr(A_CNT, 16'h0001);
        presc_tick = 4'h1; bus_sel = 1; bus_wr = 1; bus_addr = A_CNT; bus_wdata = 16'h1234;
        cyc();
        rd_chk(A_CNT, 16'h1234, "R11 write beats match clear");
        wr(A_CTRL, ctl(0, 0, 1));
        presc_tick = 4'h1; clr_trig = 1;
        bus_sel = 1; bus_wr = 1; bus_addr = A_CNT; bus_wdata = 16'hABCD;
        cyc();
        rd_chk(A_CNT, 16'hABCD, "R11 write beats trigger clear");

        // R12 byte accesses
        bus_sel = 1; bus_wr = 1; bus_addr = A_CNT; bus_be = 2'b01; bus_wdata = 16'h0077; cyc();
        rd_chk(A_CNT, 16'hABCD, "R12 byte write ignored");
        bus_sel = 1; bus_wr = 1; bus_addr = A_CMP; bus_be = 2'b10; bus_wdata = 16'h7700; cyc();
        rd_chk(A_CMP, 16'h0001, "R12 byte write cmp ignored");
        bus_sel = 1; bus_wr = 0; bus_addr = A_CNT; bus_be = 2'b01;
        #1 d = bus_rdata;
        cyc();
        chk("R12 byte read zero", d, 16'h0000);

        // R1 standby clears counter and flag
        rd_chk(A_STAT, 16'h0001, "R1 flag before standby");
        stby_hw = 1; cyc();
        rd_chk(A_CNT, 16'h0000, "R1 hw standby cnt");
        rd_chk(A_STAT, 16'h0000, "R1 hw standby flag");
        wr(A_CNT, 16'h0042);
        stby_sw = 1; presc_tick = 4'h1; cyc();
        rd_chk(A_CNT, 16'h0000, "R1 sw standby cnt");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule